// File: doc/BRIEF.md
# Centralized Exception and Interrupt Control Unit

This unit sits beside the pipeline of a small processor and decides, each cycle, whether the instruction at the current PC must be abandoned in favour of a single fixed handler. Four internal fault requests and eight pending interrupt sources (six external lines and two software-settable bits) compete. When a fault or an enabled interrupt wins, the unit raises a redirect strobe that carries the handler address. In the same cycle it captures the resume PC, records a cause code and a branch-delay flag, and pushes a three-level enable/privilege stack held in the low bits of its status word.

Software reaches three control registers through a read-select port and a write port. These are the mode word (status), the cause word and the saved exception PC. A return strobe pops the mode stack and leaves everything else alone. The handler software decodes the cause word itself, so there is one entry point and no vector table.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the status, cause and saved-PC registers read zero, and `take` is low.
- R2: The cause word carries the BD flag in bit 31 and a 4-bit code in bits 5..2; bits 1..0, 7..6 and 30..16 always read zero. Codes: 0 external/software interrupt, 4 load address fault (`fault_req[0]`), 5 store address fault (`fault_req[1]`), 11 coprocessor-unusable (`fault_req[2]`), 12 arithmetic overflow (`fault_req[3]`).
- R3: Cause bits 15..10 show `irq_in[5:0]` as sampled at the previous clock edge. Bits 9..8 are the two software interrupt bits.
- R4: `take` rises in the same cycle as a winning request, and `target_pc` is then 0x80000080 (zero otherwise). At that clock edge the saved PC is loaded with `pc_in` and the cause code is recorded.
- R5: If `in_delay_slot` is high when an exception is taken, cause bit 31 is set and the saved PC is `pc_in - 4`; otherwise bit 31 is cleared.
- R6: Any asserted fault request causes a take and beats any interrupt in the same cycle. Among coinciding faults the lowest code wins.
- R7: An interrupt is taken only when a pending bit (cause bits 15..8) has its mask bit (status bits 15..8) set and status bit 0 (current IE) is 1.
- R8: On a take, status bits 5..2 receive the old bits 3..0 and bits 1..0 (current IE, current KU) become 0.
- R9: A `rfe` pulse with no take moves status bits 5..2 into bits 3..0 and keeps bits 5..4. It raises no redirect and leaves the saved PC unchanged.
- R10: Writes use `cp_sel` 0 = status, 1 = cause, 2 = saved PC. Status accepts bits 15..8 and 5..0 only. Cause accepts bits 9..8 only. The saved PC ignores writes. A take in the same cycle blocks any write or `rfe`.
- R11: `cp_rd_data` shows the register chosen by `cp_rd_sel` (0 status, 1 cause, 2 saved PC) combinationally. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_req | input | 4 | Internal fault requests (load, store, coprocessor, overflow) |
| irq_in | input | 6 | External interrupt lines |
| pc_in | input | 32 | PC of the instruction at the exception point |
| in_delay_slot | input | 1 | That instruction sits in a branch delay slot |
| rfe | input | 1 | Return-from-exception pulse |
| cp_wr_en | input | 1 | Control register write strobe |
| cp_sel | input | 2 | Write register select |
| cp_wr_data | input | 32 | Write data |
| cp_rd_sel | input | 2 | Read register select |
| cp_rd_data | output | 32 | Read data |
| take | output | 1 | Exception taken this cycle |
| target_pc | output | 32 | Handler address while `take` is high |

## Verification
The bench builds the unit with its default parameters: a 32-bit PC, the 0x80000080 handler entry, six external and two software interrupt sources, and a 4-byte instruction step. With eight pending sources the whole mask byte is live. This lets the bench show a masked interrupt that stays pending and an unmasked one that is taken. The 4-byte step makes the delay-slot PC adjustment visible as a fixed offset. The directed sequences also cover a fault and an interrupt arriving together, and a write that collides with a take.

// File: rtl/trap_pkg.sv
// Shared definitions for the exception control unit: fault codes and
// control register selects. Assumes four internal fault sources.
package trap_pkg;
    localparam int NUM_FAULTS = 4;

    typedef enum logic [3:0] {
        EXC_IRQ   = 4'd0,
        EXC_LOAD  = 4'd4,
        EXC_STORE = 4'd5,
        EXC_COPU  = 4'd11,
        EXC_OVF   = 4'd12
    } exc_code_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_NONE   = 2'd3
    } creg_sel_e;

    // Map a fault request index to its cause code (index order = priority)
    function automatic exc_code_e fault_code(input int idx);
        case (idx)
            0:       return EXC_LOAD;
            1:       return EXC_STORE;
            2:       return EXC_COPU;
            default: return EXC_OVF;
        endcase
    endfunction
endpackage

// File: rtl/trap_arbiter.sv
// Decides whether an exception is taken this cycle and which code it gets.
// Assumes fault_req index order equals ascending code order, so index 0 wins.
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int NUM_PEND = 8
) (
    input  logic [NUM_FAULTS-1:0] fault_req,
    input  logic [NUM_PEND-1:0]   pend,
    input  logic [NUM_PEND-1:0]   mask,
    input  logic                  ie,
    output logic                  take,
    output exc_code_e             code
);
    logic irq_ok;

    // Pick the lowest-indexed fault; otherwise the interrupt code
    always_comb begin
        irq_ok = ie && (|(pend & mask));
        code   = EXC_IRQ;
        for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
            if (fault_req[i]) code = fault_code(i);
        end
        take = (|fault_req) || irq_ok;
    end
endmodule

// File: rtl/trap_mode_stack.sv
// Status register: a stack of IE/KU pairs in the low bits plus an interrupt
// mask in bits 8 and up. Priority: enter > leave > software write.
module trap_mode_stack #(
    parameter int NUM_PEND = 8,
    parameter int LEVELS   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enter,
    input  logic                  leave,
    input  logic                  wr_en,
    input  logic [2*LEVELS-1:0]   wr_modes,
    input  logic [NUM_PEND-1:0]   wr_mask,
    output logic [31:0]           status
);
    localparam int MW = 2 * LEVELS;

    logic [MW-1:0]       modes_q;
    logic [NUM_PEND-1:0] mask_q;

    // Push on entry, pop on return, else accept a software write
    always_ff @(posedge clk) begin
        if (!rst_n)       modes_q <= '0;
        else if (enter)   modes_q <= {modes_q[MW-3:0], 2'b00};
        else if (leave)   modes_q <= {modes_q[MW-1 -: 2], modes_q[MW-1:2]};
        else if (wr_en)   modes_q <= wr_modes;
    end

    // Mask changes only through a software write with no stack motion
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '0;
        else if (wr_en && !enter && !leave)  mask_q <= wr_mask;
    end

    // Assemble the visible status word
    always_comb begin
        status               = '0;
        status[8 +: NUM_PEND] = mask_q;
        status[MW-1:0]       = modes_q;
    end
endmodule

// File: rtl/trap_cause_epc.sv
// Cause word and saved exception PC. Pending external lines are registered
// every cycle; code, BD and saved PC load only when an exception is taken.
module trap_cause_epc
    import trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NUM_HW     = 6,
    parameter int NUM_SW     = 2,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  exc_code_e         code,
    input  logic              in_slot,
    input  logic [XLEN-1:0]   pc,
    input  logic [NUM_HW-1:0] hw_irq,
    input  logic              sw_wr_en,
    input  logic [NUM_SW-1:0] sw_wr_data,
    output logic [31:0]       cause,
    output logic [XLEN-1:0]   epc
);
    logic [3:0]        code_q;
    logic              bd_q;
    logic [NUM_HW-1:0] hw_q;
    logic [NUM_SW-1:0] sw_q;
    logic [XLEN-1:0]   epc_q;

    // Sample external lines into the pending field each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) hw_q <= '0;
        else        hw_q <= hw_irq;
    end

    // Record code, delay-slot flag and resume PC on a take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            bd_q   <= 1'b0;
            epc_q  <= '0;
        end else if (take) begin
            code_q <= code;
            bd_q   <= in_slot;
            epc_q  <= in_slot ? pc - XLEN'(INSN_BYTES) : pc;
        end
    end

    // Software interrupt bits, writable when no take collides
    always_ff @(posedge clk) begin
        if (!rst_n)                sw_q <= '0;
        else if (sw_wr_en && !take) sw_q <= sw_wr_data;
    end

    // Assemble the visible cause word
    always_comb begin
        cause                      = '0;
        cause[31]                  = bd_q;
        cause[5:2]                 = code_q;
        cause[8 +: NUM_SW]         = sw_q;
        cause[8 + NUM_SW +: NUM_HW] = hw_q;
    end

    assign epc = epc_q;
endmodule

// File: rtl/trap_ctrl.sv
// Top of the exception control unit: arbitration, status stack, cause/EPC
// storage and the software access port. Assumes NUM_HW_IRQ + NUM_SW_IRQ <= 8.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0080,
    parameter int              NUM_HW_IRQ = 6,
    parameter int              NUM_SW_IRQ = 2,
    parameter int              INSN_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_req,
    input  logic [NUM_HW_IRQ-1:0] irq_in,
    input  logic [XLEN-1:0]       pc_in,
    input  logic                  in_delay_slot,
    input  logic                  rfe,
    input  logic                  cp_wr_en,
    input  logic [1:0]            cp_sel,
    input  logic [31:0]           cp_wr_data,
    input  logic [1:0]            cp_rd_sel,
    output logic [XLEN-1:0]       cp_rd_data,
    output logic                  take,
    output logic [XLEN-1:0]       target_pc
);
    localparam int NUM_PEND = NUM_HW_IRQ + NUM_SW_IRQ;
    localparam int LEVELS   = 3;

    logic [31:0]     status_w;
    logic [31:0]     cause_w;
    logic [XLEN-1:0] epc_w;
    exc_code_e       code_w;
    logic            st_wr, cause_wr, leave;
    logic            wr_unused;

    // Gate software writes and returns behind a take
    always_comb begin
        st_wr    = cp_wr_en && (creg_sel_e'(cp_sel) == SEL_STATUS) && !take;
        cause_wr = cp_wr_en && (creg_sel_e'(cp_sel) == SEL_CAUSE);
        leave    = rfe && !take;
    end

    assign wr_unused = ^{cp_wr_data[31:16], cp_wr_data[7:6]};

    trap_arbiter #(.NUM_PEND(NUM_PEND)) u_arb (
        .fault_req (fault_req),
        .pend      (cause_w[8 +: NUM_PEND]),
        .mask      (status_w[8 +: NUM_PEND]),
        .ie        (status_w[0]),
        .take      (take),
        .code      (code_w)
    );

    trap_mode_stack #(.NUM_PEND(NUM_PEND), .LEVELS(LEVELS)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (take),
        .leave    (leave),
        .wr_en    (st_wr),
        .wr_modes (cp_wr_data[2*LEVELS-1:0]),
        .wr_mask  (cp_wr_data[8 +: NUM_PEND]),
        .status   (status_w)
    );

    trap_cause_epc #(
        .XLEN(XLEN), .NUM_HW(NUM_HW_IRQ), .NUM_SW(NUM_SW_IRQ), .INSN_BYTES(INSN_BYTES)
    ) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .code       (code_w),
        .in_slot    (in_delay_slot),
        .pc         (pc_in),
        .hw_irq     (irq_in),
        .sw_wr_en   (cause_wr),
        .sw_wr_data (cp_wr_data[8 +: NUM_SW_IRQ]),
        .cause      (cause_w),
        .epc        (epc_w)
    );

    // Read mux and redirect address
    always_comb begin
        case (creg_sel_e'(cp_rd_sel))
            SEL_STATUS: cp_rd_data = XLEN'(status_w);
            SEL_CAUSE:  cp_rd_data = XLEN'(cause_w);
            SEL_EPC:    cp_rd_data = epc_w;
            default:    cp_rd_data = '0;
        endcase
        target_pc = take ? HANDLER_PC : '0;
    end
endmodule

// File: rtl/trap_ctrl_chk.sv
// Property checker for trap_ctrl, bound to every instance of it.
module trap_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic            rfe,
    input logic [3:0]      fault_req,
    input logic            in_delay_slot,
    input logic [XLEN-1:0] pc_in,
    input logic [31:0]     status,
    input logic [31:0]     cause,
    input logic [XLEN-1:0] epc
);
    assert_entry_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (status[1:0] == 2'b00) && (status[5:2] == $past(status[3:0])));

    assert_return_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !take) |=> (status[3:0] == $past(status[5:2]))
                        && (status[5:4] == $past(status[5:4])) && $stable(epc));

    assert_epc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(epc));

    assert_fault_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_req) |-> take);

    assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_req) |=> (cause[5:2] != 4'd0));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|fault_req) && !status[0]) |-> !take);

    assert_epc_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_delay_slot) |=> (epc == $past(pc_in)));

    assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cause[1:0] == 2'b00) && (cause[7:6] == 2'b00) && (cause[30:16] == 15'd0));
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .rfe           (rfe),
    .fault_req     (fault_req),
    .in_delay_slot (in_delay_slot),
    .pc_in         (pc_in),
    .status        (status_w),
    .cause         (cause_w),
    .epc           (epc_w)
);

// File: tb/tb_trap_ctrl.sv
module tb_trap_ctrl;
    localparam logic [31:0] HANDLER = 32'h8000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fault_req = '0;
    logic [5:0]  irq_in = '0;
    logic [31:0] pc_in = '0;
    logic        in_delay_slot = 1'b0;
    logic        rfe = 1'b0;
    logic        cp_wr_en = 1'b0;
    logic [1:0]  cp_sel = '0;
    logic [31:0] cp_wr_data = '0;
    logic [1:0]  cp_rd_sel = '0;
    logic [31:0] cp_rd_data;
    logic        take;
    logic [31:0] target_pc;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    trap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .irq_in(irq_in),
        .pc_in(pc_in), .in_delay_slot(in_delay_slot), .rfe(rfe),
        .cp_wr_en(cp_wr_en), .cp_sel(cp_sel), .cp_wr_data(cp_wr_data),
        .cp_rd_sel(cp_rd_sel), .cp_rd_data(cp_rd_data),
        .take(take), .target_pc(target_pc)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        cp_rd_sel = sel;
        #1;
        val = cp_rd_data;
    endtask

    task automatic expect_regs(input string req, input logic [31:0] st, input logic [31:0] ca, input logic [31:0] ep);
        logic [31:0] v;
        rd(2'd0, v); chk(req, "status", v, st);
        rd(2'd1, v); chk(req, "cause", v, ca);
        rd(2'd2, v); chk(req, "epc", v, ep);
    endtask

    task automatic cp_write(input logic [1:0] sel, input logic [31:0] data);
        cp_wr_en = 1'b1; cp_sel = sel; cp_wr_data = data;
        tick;
        cp_wr_en = 1'b0;
    endtask

    // Fault request, same-cycle redirect, then register contents
    task automatic do_fault(input string req, input logic [3:0] f, input logic [31:0] pc,
                            input logic slot, input logic [31:0] st, input logic [31:0] ca, input logic [31:0] ep);
        fault_req = f; pc_in = pc; in_delay_slot = slot;
        #1;
        chk("R6", "take on fault", {31'd0, take}, 32'd1);
        chk("R4", "target_pc", target_pc, HANDLER);
        tick;
        fault_req = '0; in_delay_slot = 1'b0;
        expect_regs(req, st, ca, ep);
    endtask

    // Return pulse: no redirect, status popped, saved PC kept
    task automatic do_rfe(input logic [31:0] st, input logic [31:0] ep);
        logic [31:0] v;
        rfe = 1'b1;
        #1;
        chk("R9", "no take on rfe", {31'd0, take}, 32'd0);
        tick;
        rfe = 1'b0;
        rd(2'd0, v); chk("R9", "status after rfe", v, st);
        rd(2'd2, v); chk("R9", "epc after rfe", v, ep);
    endtask

    task automatic t_reset;
        chk("R1", "take", {31'd0, take}, 32'd0);
        expect_regs("R1", 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_status_write;
        logic [31:0] v;
        cp_write(2'd0, 32'h8000_FFD5);
        rd(2'd0, v); chk("R10", "status write mask", v, 32'h0000_FF15);
    endtask

    task automatic t_faults;
        do_fault("R8", 4'b1000, 32'h1000, 1'b0, 32'hFF14, 32'h30, 32'h1000);
        do_rfe(32'hFF15, 32'h1000);
        do_fault("R6", 4'b1001, 32'h2000, 1'b0, 32'hFF14, 32'h10, 32'h2000);
        do_rfe(32'hFF15, 32'h2000);
        do_fault("R6", 4'b1110, 32'h2100, 1'b0, 32'hFF14, 32'h14, 32'h2100);
        do_rfe(32'hFF15, 32'h2100);
        do_fault("R2", 4'b1100, 32'h2200, 1'b0, 32'hFF14, 32'h2C, 32'h2200);
        do_rfe(32'hFF15, 32'h2200);
    endtask

    task automatic t_delay_slot;
        do_fault("R5", 4'b0001, 32'h3008, 1'b1, 32'hFF14, 32'h8000_0010, 32'h3004);
        do_rfe(32'hFF15, 32'h3004);
    endtask

    task automatic t_reg_access;
        logic [31:0] v;
        cp_write(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, v); chk("R10", "epc write ignored", v, 32'h3004);
        rd(2'd3, v); chk("R11", "select 3", v, 32'h0);
    endtask

    task automatic t_irq_mask;
        cp_write(2'd0, 32'h0000_FB15);
        irq_in = 6'b000001; pc_in = 32'h4000;
        tick;
        chk("R7", "masked irq not taken", {31'd0, take}, 32'd0);
        expect_regs("R3", 32'hFB15, 32'h8000_0410, 32'h3004);
        cp_write(2'd0, 32'h0000_FF15);
        chk("R7", "unmasked irq taken", {31'd0, take}, 32'd1);
        chk("R4", "irq target", target_pc, HANDLER);
        tick;
        expect_regs("R4", 32'hFF14, 32'h0000_0400, 32'h4000);
        chk("R7", "IE=0 blocks irq", {31'd0, take}, 32'd0);
        irq_in = '0;
        tick;
        expect_regs("R3", 32'hFF14, 32'h0, 32'h4000);
        do_rfe(32'hFF15, 32'h4000);
    endtask

    task automatic t_fault_over_irq;
        irq_in = 6'b100000;
        tick;
        fault_req = 4'b0010; pc_in = 32'h5000;
        #1;
        tick;
        fault_req = '0; irq_in = '0;
        expect_regs("R6", 32'hFF14, 32'h0000_8014, 32'h5000);
        tick;
        do_rfe(32'hFF15, 32'h5000);
    endtask

    task automatic t_soft_irq;
        logic [31:0] v;
        pc_in = 32'h6000;
        cp_write(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R10", "cause write bits 9..8 only", v, 32'h0000_0314);
        chk("R7", "soft irq taken", {31'd0, take}, 32'd1);
        cp_write(2'd1, 32'h0);
        expect_regs("R10", 32'hFF14, 32'h0000_0300, 32'h6000);
        cp_write(2'd1, 32'h0);
        rd(2'd1, v); chk("R3", "soft bits cleared", v, 32'h0);
        do_rfe(32'hFF15, 32'h6000);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick;
        t_reset();
        t_status_write();
        t_faults();
        t_delay_slot();
        t_reg_access();
        t_irq_mask();
        t_fault_over_irq();
        t_soft_irq();
        summary();
    end
endmodule